// File: doc/BRIEF.md
# Per-Agent Memory Request Arbiter

This block sits in front of a single DRAM command port. It chooses which of five requesting agents may present commands there. Each agent raises a request level and drives a command word. The arbiter returns a one-hot grant and forwards the granted agent's command to the port. A command is taken when the port's ready is high while the forwarded command is valid.

Three programmable values per agent set the grant order in place of plain rotation. The first is a command quota: the number of accepted commands an agent keeps the grant for. The second is a burst cap, which shortens that stay. The third is a service period, counted in units of four clocks. An agent left unserved for longer than its period is moved ahead of the others. Software programs these values indirectly. It first writes a select register with the agent number multiplied by the width of the field it wants to set. It then writes the value to that field's data address.

Top module: `mem_req_arbiter`

## Requirements
- R1: After reset the grant is zero and the command valid is low. The power-up values are: quota 0x04, 0x10, 0x10, 0x04, 0x04 for agents 0 to 4; burst cap 0x1F for agents 0 to 2 and 0x04 for agents 3 and 4; service period 0xFF for every agent. The first agent searched after reset is agent 0.
- R2: The grant is one-hot or zero. A new grant appears at the clock edge that ends an arbitration cycle. The grant is zero on the cycle after any cycle in which no agent requests.
- R3: The command valid equals the request of the granted agent. The command output carries the granted agent's command word, and it is zero while no agent holds the grant.
- R4: A grant lasts for a hold count of accepted commands. The hold count is the smaller of the agent's quota and burst cap, and a result of 0 counts as 1. The hold count is sampled when the grant is issued. The grant also ends at once when the granted agent lowers its request.
- R5: At each arbitration the search starts at the agent after the one granted last and runs in rising index order, wrapping from 4 to 0.
- R6: Each agent's timer counts the clocks since it last held the grant, and saturates at its maximum. An agent is overdue when its timer is at least 4 times its service period. When any requesting agent is overdue, only overdue requesters take part in the search of R5.
- R7: Configuration writes use cfg_addr 0 for the select register (8 bits), 1 for the burst cap (5 bits), 2 for the service period (8 bits) and 3 for the quota (5 bits). A data write lands in agent i only if the select equals i × 5 for the cap or quota, or i × 8 for the period. A write with any other select has no effect.
- R8: The grant changes only at an arbitration point: no grant is held, the granted agent is not requesting, or an accepted command completes its hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address: 0 select, 1 burst cap, 2 period, 3 quota |
| cfg_wdata | input | 8 | Configuration write data |
| req | input | 5 | Request level, one bit per agent |
| cmd_in | input | 5×16 | Command word of each agent |
| cmd_ready | input | 1 | The DRAM command port takes the command |
| gnt | output | 5 | One-hot grant |
| cmd_valid | output | 1 | The forwarded command is valid |
| cmd_out | output | 16 | Forwarded command word |

## Verification
The assertions need no handshake rule from the agents or the port. A request may fall at any cycle, even while it waits for ready, and cmd_ready is a free level. They do assume that every input is a clean 0 or 1 at each clock edge. The bench meets this by driving only defined values at the falling edge. The random phase lets requests fall and rise at will, keeps ready random, and sends configuration writes with both valid and stray select values. It keeps periods short so that overdue agents appear often.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    CFG_SEL    = 2'd0,
    CFG_CAP    = 2'd1,
    CFG_PERIOD = 2'd2,
    CFG_QUOTA  = 2'd3
  } cfg_reg_e;

  function automatic int dflt_cap(input int agent);
    return (agent < 3) ? 31 : 4;
  endfunction

  function automatic int dflt_quota(input int agent);
    return (agent == 1 || agent == 2) ? 16 : 4;
  endfunction

  function automatic int dflt_period(input int agent);
    return (agent >= 0) ? 255 : 0;
  endfunction

endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
  import arb_pkg::*;
#(
  parameter int N_AGENTS = 5,
  parameter int CFG_W    = 8,
  parameter int CAP_W    = 5,
  parameter int PERIOD_W = 8,
  parameter int QUOTA_W  = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_i,
  input  logic [1:0]                         addr_i,
  input  logic [CFG_W-1:0]                   wdata_i,
  output logic [N_AGENTS-1:0][CAP_W-1:0]     cap_o,
  output logic [N_AGENTS-1:0][PERIOD_W-1:0]  period_o,
  output logic [N_AGENTS-1:0][QUOTA_W-1:0]   quota_o
);

  logic [CFG_W-1:0] sel_q, sel_d;
  logic             wr_sel, wr_cap, wr_per, wr_quo;

  always_comb begin
    wr_sel = wr_i && (addr_i == CFG_SEL);
    wr_cap = wr_i && (addr_i == CFG_CAP);
    wr_per = wr_i && (addr_i == CFG_PERIOD);
    wr_quo = wr_i && (addr_i == CFG_QUOTA);
    sel_d  = wr_sel ? wdata_i : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
    localparam logic [CFG_W-1:0] CAP_SEL = CFG_W'(i * CAP_W);
    localparam logic [CFG_W-1:0] PER_SEL = CFG_W'(i * PERIOD_W);
    localparam logic [CFG_W-1:0] QUO_SEL = CFG_W'(i * QUOTA_W);

    logic [CAP_W-1:0]    cap_q, cap_d;
    logic [PERIOD_W-1:0] per_q, per_d;
    logic [QUOTA_W-1:0]  quo_q, quo_d;

    always_comb begin
      cap_d = (wr_cap && sel_q == CAP_SEL) ? wdata_i[CAP_W-1:0]    : cap_q;
      per_d = (wr_per && sel_q == PER_SEL) ? wdata_i[PERIOD_W-1:0] : per_q;
      quo_d = (wr_quo && sel_q == QUO_SEL) ? wdata_i[QUOTA_W-1:0]  : quo_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q <= CAP_W'(dflt_cap(i));
        per_q <= PERIOD_W'(dflt_period(i));
        quo_q <= QUOTA_W'(dflt_quota(i));
      end else begin
        cap_q <= cap_d;
        per_q <= per_d;
        quo_q <= quo_d;
      end
    end

    assign cap_o[i]    = cap_q;
    assign period_o[i] = per_q;
    assign quota_o[i]  = quo_q;
  end

endmodule

// File: rtl/arb_period_timer.sv
module arb_period_timer #(
  parameter int PERIOD_W = 8,
  localparam int TMR_W   = PERIOD_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                overdue_o
);

  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en    = clr_i || (cnt_q != TMR_MAX);
    cnt_d     = clr_i ? '0 : cnt_q + TMR_W'(1);
    overdue_o = cnt_q >= {period_i, 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_AGENTS = 5,
  localparam int IDX_W   = $clog2(N_AGENTS)
) (
  input  logic [N_AGENTS-1:0] mask_i,
  input  logic [IDX_W-1:0]    last_i,
  output logic                found_o,
  output logic [IDX_W-1:0]    idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N_AGENTS; k >= 1; k--) begin
      int j;
      j = (int'(last_i) + k) % N_AGENTS;
      if (mask_i[j]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
  import arb_pkg::*;
#(
  parameter int N_AGENTS = 5,
  parameter int CMD_W    = 16,
  parameter int CFG_W    = 8,
  parameter int CAP_W    = 5,
  parameter int PERIOD_W = 8,
  parameter int QUOTA_W  = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_wr,
  input  logic [1:0]                      cfg_addr,
  input  logic [CFG_W-1:0]                cfg_wdata,
  input  logic [N_AGENTS-1:0]             req,
  input  logic [N_AGENTS-1:0][CMD_W-1:0]  cmd_in,
  input  logic                            cmd_ready,
  output logic [N_AGENTS-1:0]             gnt,
  output logic                            cmd_valid,
  output logic [CMD_W-1:0]                cmd_out
);

  localparam int IDX_W  = $clog2(N_AGENTS);
  localparam int HOLD_W = (CAP_W > QUOTA_W) ? CAP_W : QUOTA_W;
  localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(N_AGENTS - 1);

  // reset: asserted at once, released after two clock edges
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic [N_AGENTS-1:0][CAP_W-1:0]    cap_a;
  logic [N_AGENTS-1:0][PERIOD_W-1:0] period_a;
  logic [N_AGENTS-1:0][QUOTA_W-1:0]  quota_a;
  logic [N_AGENTS-1:0]               overdue;

  arb_cfg_regs #(
    .N_AGENTS(N_AGENTS), .CFG_W(CFG_W), .CAP_W(CAP_W),
    .PERIOD_W(PERIOD_W), .QUOTA_W(QUOTA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(cfg_wr), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .cap_o(cap_a), .period_o(period_a), .quota_o(quota_a)
  );

  logic [N_AGENTS-1:0] gnt_q, gnt_d;
  logic [IDX_W-1:0]    gidx_q, gidx_d, last_q, last_d;
  logic [HOLD_W-1:0]   cnt_q, cnt_d, lim_q, lim_d;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_tmr
    arb_period_timer #(.PERIOD_W(PERIOD_W)) u_tmr (
      .clk(clk), .rst_n(rst_sync_n), .clr_i(gnt_q[i]),
      .period_i(period_a[i]), .overdue_o(overdue[i])
    );
  end

  logic                req_g, hs, done, rearb, found;
  logic [N_AGENTS-1:0] urgent, pick_mask;
  logic [IDX_W-1:0]    pick_idx;
  logic [HOLD_W-1:0]   cap_x, quo_x, hold_raw, hold_new;
  logic [HOLD_W:0]     cnt_inc;
  logic                state_en;

  arb_rr_pick #(.N_AGENTS(N_AGENTS)) u_pick (
    .mask_i(pick_mask), .last_i(last_q), .found_o(found), .idx_o(pick_idx)
  );

  always_comb begin
    req_g     = |(req & gnt_q);
    hs        = req_g && cmd_ready;
    cnt_inc   = {1'b0, cnt_q} + (HOLD_W+1)'(1);
    done      = hs && (cnt_inc >= {1'b0, lim_q});
    rearb     = !req_g || done;
    urgent    = req & overdue;
    pick_mask = (|urgent) ? urgent : req;
    cap_x     = HOLD_W'(cap_a[pick_idx]);
    quo_x     = HOLD_W'(quota_a[pick_idx]);
    hold_raw  = (cap_x < quo_x) ? cap_x : quo_x;
    hold_new  = (hold_raw == '0) ? HOLD_W'(1) : hold_raw;
    state_en  = rearb || hs;

    gnt_d  = gnt_q;
    gidx_d = gidx_q;
    last_d = last_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    if (rearb) begin
      if (found) begin
        gnt_d  = N_AGENTS'(1) << pick_idx;
        gidx_d = pick_idx;
        last_d = pick_idx;
        cnt_d  = '0;
        lim_d  = hold_new;
      end else begin
        gnt_d = '0;
      end
    end else if (hs) begin
      cnt_d = cnt_inc[HOLD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gnt_q  <= '0;
      gidx_q <= '0;
      last_q <= LAST_INIT;
      cnt_q  <= '0;
      lim_q  <= HOLD_W'(1);
    end else if (state_en) begin
      gnt_q  <= gnt_d;
      gidx_q <= gidx_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
    end
  end

  assign gnt       = gnt_q;
  assign cmd_valid = req_g;
  assign cmd_out   = (|gnt_q) ? cmd_in[gidx_q] : '0;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(gnt)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req == '0) |=> (gnt == '0)); // R2
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && !cmd_ready) |=> $stable(gnt)); // R8
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gnt != '0) |-> (cnt_q < lim_q)); // R4
  AST_URGENT_WIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rearb && (urgent != '0)) |=> ((gnt & $past(urgent)) != '0)); // R6

endmodule

// File: tb/tb_mem_req_arbiter.sv
module tb_mem_req_arbiter;
  localparam int N = 5;
  localparam int CW = 16;
  localparam int TMR_MAX = 1023;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [N-1:0] req;
  logic [N-1:0][CW-1:0] cmd_in;
  logic cmd_ready;
  logic [N-1:0] gnt;
  logic cmd_valid;
  logic [CW-1:0] cmd_out;

  always #2 clk = ~clk;

  mem_req_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req(req), .cmd_in(cmd_in), .cmd_ready(cmd_ready),
    .gnt(gnt), .cmd_valid(cmd_valid), .cmd_out(cmd_out)
  );

  int checks = 0;
  int errors = 0;
  string phase = "R1 reset";

  // reference model state
  int m_gnt, m_last, m_cnt, m_lim, m_sel;
  int m_cap[N], m_quota[N], m_period[N], m_tmr[N];

  function automatic int hold_of(input int a);
    int h;
    h = (m_cap[a] < m_quota[a]) ? m_cap[a] : m_quota[a];
    return (h == 0) ? 1 : h;
  endfunction

  function automatic logic [N-1:0] exp_gnt();
    return (m_gnt >= 0) ? (N'(1) << m_gnt) : '0;
  endfunction

  function automatic logic exp_valid();
    return (m_gnt >= 0) ? req[m_gnt] : 1'b0;
  endfunction

  function automatic logic [CW-1:0] exp_cmd();
    return (m_gnt >= 0) ? cmd_in[m_gnt] : '0;
  endfunction

  task automatic model_reset();
    m_gnt = -1; m_last = N - 1; m_cnt = 0; m_lim = 1; m_sel = 0;
    for (int i = 0; i < N; i++) begin
      m_cap[i] = (i < 3) ? 31 : 4;
      m_quota[i] = (i == 1 || i == 2) ? 16 : 4;
      m_period[i] = 255;
      m_tmr[i] = 0;
    end
  endtask

  task automatic model_step();
    logic hs, rearb;
    logic [N-1:0] urg, mask;
    int pick;
    hs = (m_gnt >= 0) && req[m_gnt] && cmd_ready;
    rearb = !((m_gnt >= 0) && req[m_gnt]) || (hs && (m_cnt + 1 >= m_lim));
    for (int i = 0; i < N; i++) urg[i] = req[i] && (m_tmr[i] >= 4 * m_period[i]);
    mask = (urg != '0) ? urg : req;
    for (int i = 0; i < N; i++) begin
      if (i == m_gnt) m_tmr[i] = 0;
      else if (m_tmr[i] < TMR_MAX) m_tmr[i]++;
    end
    if (rearb) begin
      pick = -1;
      for (int k = 1; k <= N; k++)
        if (pick < 0 && mask[(m_last + k) % N]) pick = (m_last + k) % N;
      if (pick >= 0) begin
        m_gnt = pick; m_last = pick; m_cnt = 0; m_lim = hold_of(pick);
      end else m_gnt = -1;
    end else if (hs) m_cnt++;
    if (cfg_wr) begin
      case (cfg_addr)
        2'd0: m_sel = cfg_wdata;
        2'd1: for (int i = 0; i < N; i++) if (m_sel == i * 5) m_cap[i] = cfg_wdata & 31;
        2'd2: for (int i = 0; i < N; i++) if (m_sel == i * 8) m_period[i] = cfg_wdata;
        default: for (int i = 0; i < N; i++) if (m_sel == i * 5) m_quota[i] = cfg_wdata & 31;
      endcase
    end
  endtask

  task automatic check_outputs();
    checks++;
    if (gnt !== exp_gnt()) begin
      errors++;
      $display("FAIL %s gnt actual=%b expected=%b", phase, gnt, exp_gnt());
    end
    checks++;
    if (cmd_valid !== exp_valid()) begin
      errors++;
      $display("FAIL %s cmd_valid actual=%b expected=%b", phase, cmd_valid, exp_valid());
    end
    checks++;
    if (cmd_out !== exp_cmd()) begin
      errors++;
      $display("FAIL %s cmd_out actual=%h expected=%h", phase, cmd_out, exp_cmd());
    end
  endtask

  // called right after a falling edge with inputs already set
  task automatic tick();
    #1 check_outputs();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic run(input logic [N-1:0] r, input int n, input int ready_pct);
    for (int c = 0; c < n; c++) begin
      req = r;
      for (int i = 0; i < N; i++) cmd_in[i] = CW'($urandom);
      cmd_ready = ($urandom % 100) < ready_pct;
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req = '0; cmd_in = '0; cmd_ready = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);

    phase = "R1 reset";
    run('0, 4, 50);

    phase = "R4 hold";
    run(5'b00011, 60, 70);

    phase = "R7 select";
    cfg_write(2'd0, 8'd6);  cfg_write(2'd3, 8'd1);
    cfg_write(2'd0, 8'd5);  cfg_write(2'd2, 8'd1);
    cfg_write(2'd0, 8'd0);  cfg_write(2'd3, 8'd2);
    cfg_write(2'd0, 8'd5);  cfg_write(2'd1, 8'd3);
    run(5'b00011, 40, 100);

    phase = "R6 period";
    cfg_write(2'd0, 8'd16); cfg_write(2'd2, 8'd2);
    run(5'b00111, 80, 100);

    phase = "R5 rotate";
    for (int i = 0; i < N; i++) begin
      cfg_write(2'd0, 8'(i * 5)); cfg_write(2'd3, 8'd1);
    end
    run(5'b11111, 40, 100);
    run(5'b11010, 20, 60);

    phase = "R2 idle";
    run('0, 6, 50);

    phase = "R8 R3 random";
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        if (!req[i]) req[i] = ($urandom % 100) < 30;
        else req[i] = ($urandom % 100) >= 6;
        cmd_in[i] = CW'($urandom);
      end
      cmd_ready = ($urandom % 100) < 70;
      if (($urandom % 100) < 4) begin
        cfg_wr = 1'b1;
        cfg_addr = 2'($urandom % 4);
        case (cfg_addr)
          2'd0: cfg_wdata = (($urandom % 2) == 0) ? 8'($urandom % 41) : 8'(($urandom % 5) * (($urandom % 2) ? 5 : 8));
          2'd2: cfg_wdata = 8'($urandom % 6);
          default: cfg_wdata = 8'($urandom % 8);
        endcase
      end else cfg_wr = 1'b0;
      tick();
    end
    cfg_wr = 1'b0;

    phase = "R2 idle end";
    run('0, 4, 50);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule